// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a programmable down-counting timer. It counts pulses of a 32768 Hz enable (`tick_i`) that arrive in the fast system clock domain. A 16-bit reload value N sets the period to N ticks, so the expiry rate is 32768/N Hz. A reload of `0x8000 >> k` therefore gives 2^k Hz. On every expiry the timer sets a sticky flag and, when the interrupt is enabled, asserts `irq_o`. In periodic mode it reloads itself and keeps running. In one-shot mode it drops its own enable.

Software reaches the block over a simple byte-wide write port with a combinational read path. One control byte holds the timer fields together with the control bits of a neighbouring watchdog. That watchdog's busy status gates the timer enable. A separate register lets software restart the current count from the full reload, so the next period is not shortened by earlier ticks.

Register map (byte addresses): control at 0x11, reload low byte at 0x12, reload high byte at 0x13, count restart at 0x20. Control bits: 7 watchdog busy (read-only), 6 watchdog enable, 5 watchdog restart, 4 watchdog flag, 3 timer enable, 2 timer interrupt enable, 1 timer flag, 0 timer mode.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0 (bit 7 of control shows `wdog_busy_i`), and `irq_o`, `wdog_en_o` and `wdog_kick_o` are 0. Unmapped addresses read 0.
- R2: A write to 0x12 is held in a staging byte and does not change the readback of 0x12. A write to 0x13 commits the high byte together with the staged low byte, after which 0x12 and 0x13 read back the new value.
- R3: Setting control bit 3 (timer enable) loads the count with the reload N. The timer flag (control bit 1) then sets on exactly the Nth `tick_i` pulse, not earlier. Ticks while the enable is 0 have no effect.
- R4: A reload value of 0 acts as 65536 ticks.
- R5: With control bit 0 = 1 (periodic), expiry reloads the count and leaves the enable set, so the next expiry comes exactly N ticks later.
- R6: With control bit 0 = 0 (one-shot), expiry clears the timer enable and further ticks set no flag.
- R7: Writing 1 to control bit 1 clears the timer flag. Writing 0 leaves it unchanged. An expiry in the same cycle as the clear keeps the flag set.
- R8: `irq_o` is 1 exactly when the timer flag and control bit 2 (interrupt enable) are both 1.
- R9: A write that would set the timer enable while `wdog_busy_i` is 1 leaves the enable at 0. Clearing the enable is always accepted.
- R10: Writing 0x00 to 0x20 reloads the count with N, so the next expiry comes N ticks later. Writing any nonzero value there is ignored.
- R11: Control bit 6 is a plain read/write bit that drives `wdog_en_o`. Writing 1 to bit 5 gives a one-cycle `wdog_kick_o` pulse in the next cycle, and bit 5 always reads 0. Bit 4 is set by `wdog_bark_i` and cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse at 32768 Hz |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| wdog_busy_i | input | 1 | Watchdog busy status |
| wdog_bark_i | input | 1 | Watchdog expiry event, sets control bit 4 |
| wdog_en_o | output | 1 | Watchdog enable (control bit 6) |
| wdog_kick_o | output | 1 | One-cycle watchdog restart pulse |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The bound checker watches, on every cycle, invariants that hold whatever software does:
- a running count stays between 1 and 65536;
- every expiry leaves the flag set;
- one-shot expiry drops the enable and periodic expiry keeps it;
- the enable never rises after a cycle in which the watchdog was busy;
- the interrupt only rises after an expiry or after the interrupt enable is set.

Only the bench scenarios can show the exact period length for a given reload, including 0 and 0x0800. The same holds for the staged reload commit, the restart register ignoring nonzero data, flag clearing, and the watchdog kick and flag bits as seen at the register interface.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned BUS_W    = 8;
  localparam int unsigned RELOAD_W = 16;

  localparam logic [BUS_W-1:0] ADDR_CTRL   = 8'h11;
  localparam logic [BUS_W-1:0] ADDR_RLD_LO = 8'h12;
  localparam logic [BUS_W-1:0] ADDR_RLD_HI = 8'h13;
  localparam logic [BUS_W-1:0] ADDR_RESTART = 8'h20;

  // Control byte, most significant field first (bit 7 .. bit 0).
  typedef struct packed {
    logic wd_busy;
    logic wd_en;
    logic wd_kick;
    logic wd_flag;
    logic tm_en;
    logic tm_ien;
    logic tm_flag;
    logic tm_periodic;
  } ctrl_t;

  localparam int unsigned BIT_WD_EN   = 6;
  localparam int unsigned BIT_WD_KICK = 5;
  localparam int unsigned BIT_WD_FLAG = 4;
  localparam int unsigned BIT_TM_EN   = 3;
  localparam int unsigned BIT_TM_IEN  = 2;
  localparam int unsigned BIT_TM_FLAG = 1;
  localparam int unsigned BIT_TM_PER  = 0;

endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tick_reload_regs.sv
module tick_reload_regs #(
  parameter int unsigned W = 16,
  localparam int unsigned HI_W = W - 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] reload_o,
  output logic [W:0]   reload_eff_o
);
  logic [7:0]   stage_q, stage_d;
  logic [W-1:0] reload_q, reload_d;

  always_comb begin
    stage_d  = stage_q;
    reload_d = reload_q;
    if (wr_lo_i) stage_d = wdata_i;
    if (wr_hi_i) reload_d = {wdata_i[HI_W-1:0], stage_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      reload_q <= '0;
    end else begin
      if (wr_lo_i) stage_q  <= stage_d;
      if (wr_hi_i) reload_q <= reload_d;
    end
  end

  assign reload_o     = reload_q;
  // A zero reload stands for the full 2^W range.
  assign reload_eff_o = (reload_q == '0) ? {1'b1, {W{1'b0}}} : {1'b0, reload_q};
endmodule

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctrl_i,
  input  logic [6:0] wdata_i,
  input  logic       busy_i,
  input  logic       bark_i,
  input  logic       expire_i,
  output ctrl_t      ctrl_o,
  output logic       te_load_o
);
  logic wd_en_q, wd_en_d;
  logic kick_q, kick_d;
  logic wd_flag_q, wd_flag_d;
  logic te_q, te_d;
  logic ien_q, ien_d;
  logic flag_q, flag_d;
  logic per_q, per_d;
  logic te_accept;

  // The enable may rise only when the watchdog is idle; clearing always works.
  assign te_accept = wdata_i[BIT_TM_EN] & (te_q | ~busy_i);
  assign te_load_o = wr_ctrl_i & wdata_i[BIT_TM_EN] & ~te_q & ~busy_i;

  always_comb begin
    wd_en_d   = wd_en_q;
    ien_d     = ien_q;
    per_d     = per_q;
    te_d      = te_q;
    kick_d    = wr_ctrl_i & wdata_i[BIT_WD_KICK];
    flag_d    = flag_q;
    wd_flag_d = wd_flag_q;
    if (wr_ctrl_i) begin
      wd_en_d = wdata_i[BIT_WD_EN];
      ien_d   = wdata_i[BIT_TM_IEN];
      per_d   = wdata_i[BIT_TM_PER];
      te_d    = te_accept;
      if (wdata_i[BIT_TM_FLAG]) flag_d    = 1'b0;
      if (wdata_i[BIT_WD_FLAG]) wd_flag_d = 1'b0;
    end
    // Events take priority over a same-cycle clear.
    if (expire_i) begin
      flag_d = 1'b1;
      if (!per_q) te_d = 1'b0;
    end
    if (bark_i) wd_flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_en_q   <= 1'b0;
      kick_q    <= 1'b0;
      wd_flag_q <= 1'b0;
      te_q      <= 1'b0;
      ien_q     <= 1'b0;
      flag_q    <= 1'b0;
      per_q     <= 1'b0;
    end else begin
      wd_en_q   <= wd_en_d;
      kick_q    <= kick_d;
      wd_flag_q <= wd_flag_d;
      te_q      <= te_d;
      ien_q     <= ien_d;
      flag_q    <= flag_d;
      per_q     <= per_d;
    end
  end

  assign ctrl_o.wd_busy     = busy_i;
  assign ctrl_o.wd_en       = wd_en_q;
  assign ctrl_o.wd_kick     = kick_q;
  assign ctrl_o.wd_flag     = wd_flag_q;
  assign ctrl_o.tm_en       = te_q;
  assign ctrl_o.tm_ien      = ien_q;
  assign ctrl_o.tm_flag     = flag_q;
  assign ctrl_o.tm_periodic = per_q;
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int unsigned W = 16,
  localparam int unsigned CNT_W = W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_eff_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(1));
  assign expire_o  = run_i & tick_i & ~load_i & last_tick;
  assign cnt_en    = load_i | (run_i & tick_i);

  always_comb begin
    if (load_i || last_tick) cnt_d = reload_eff_i;
    else                     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned RELOAD_BITS = RELOAD_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = RELOAD_BITS + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       wdog_busy_i,
  input  logic       wdog_bark_i,
  output logic       wdog_en_o,
  output logic       wdog_kick_o,
  output logic       irq_o
);
  logic                   rst_n;
  logic                   wr_ctrl, wr_lo, wr_hi, wr_restart;
  logic [RELOAD_BITS-1:0] reload;
  logic [CNT_W-1:0]       reload_eff;
  logic [CNT_W-1:0]       cnt;
  logic                   expire;
  logic                   te_load;
  logic                   cnt_load;
  ctrl_t                  ctrl;
  ctrl_t                  ctrl_rd;
  logic                   te_w, per_w, flag_w, ien_w;

  tick_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  assign wr_ctrl    = wr_en_i & (addr_i == ADDR_CTRL);
  assign wr_lo      = wr_en_i & (addr_i == ADDR_RLD_LO);
  assign wr_hi      = wr_en_i & (addr_i == ADDR_RLD_HI);
  assign wr_restart = wr_en_i & (addr_i == ADDR_RESTART) & (wdata_i == 8'h00);

  tick_reload_regs #(.W(RELOAD_BITS)) u_reload (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .wr_lo_i      (wr_lo),
    .wr_hi_i      (wr_hi),
    .wdata_i      (wdata_i),
    .reload_o     (reload),
    .reload_eff_o (reload_eff)
  );

  tick_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (wdata_i[6:0]),
    .busy_i    (wdog_busy_i),
    .bark_i    (wdog_bark_i),
    .expire_i  (expire),
    .ctrl_o    (ctrl),
    .te_load_o (te_load)
  );

  assign cnt_load = te_load | wr_restart;

  tick_down_counter #(.W(RELOAD_BITS)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .load_i       (cnt_load),
    .run_i        (ctrl.tm_en),
    .tick_i       (tick_i),
    .reload_eff_i (reload_eff),
    .expire_o     (expire),
    .cnt_o        (cnt)
  );

  assign te_w   = ctrl.tm_en;
  assign per_w  = ctrl.tm_periodic;
  assign flag_w = ctrl.tm_flag;
  assign ien_w  = ctrl.tm_ien;

  // The kick bit is a strobe and always reads back as 0.
  always_comb begin
    ctrl_rd         = ctrl;
    ctrl_rd.wd_kick = 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL)        rdata_o = ctrl_rd;
    else if (addr_i == ADDR_RLD_LO) rdata_o = reload[7:0];
    else if (addr_i == ADDR_RLD_HI) rdata_o = reload[RELOAD_BITS-1:8];
  end

  assign wdog_en_o   = ctrl.wd_en;
  assign wdog_kick_o = ctrl.wd_kick;
  assign irq_o       = flag_w & ien_w;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             te,
  input logic             periodic,
  input logic             flag,
  input logic             ien,
  input logic             irq,
  input logic             expire,
  input logic             wr_ctrl,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {(CNT_W-1){1'b0}}};

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    te |-> (cnt != '0 && cnt <= CNT_MAX));

  assert_flag_on_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> !te);

  assert_periodic_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic && !wr_ctrl) |=> te);

  assert_busy_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te) |-> !$past(busy));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $rose(ien)));
endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_tick_timer_checker (
  .clk      (clk_i),
  .rst_n    (rst_n),
  .te       (te_w),
  .periodic (per_w),
  .flag     (flag_w),
  .ien      (ien_w),
  .irq      (irq_o),
  .expire   (expire),
  .wr_ctrl  (wr_ctrl),
  .busy     (wdog_busy_i),
  .cnt      (cnt)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       wdog_busy_i = 1'b0;
  logic       wdog_bark_i = 1'b0;
  logic       wdog_en_o;
  logic       wdog_kick_o;
  logic       irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h11, A_LO = 8'h12, A_HI = 8'h13, A_RST = 8'h20;

  always #5 clk_i = ~clk_i;

  tick_timer i_tick_timer (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .wdog_busy_i, .wdog_bark_i, .wdog_en_o, .wdog_kick_o, .irq_o
  );

  function automatic int eff_period(input int rel);
    return (rel == 0) ? 65536 : rel;
  endfunction

  function automatic logic [7:0] ctrl_word(input bit te, input bit ien,
                                           input bit clr, input bit per);
    return {4'b0000, te, ien, clr, per};
  endfunction

  function automatic bit exp_irq(input bit flag, input bit ien);
    return flag & ien;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      repeat (gap) @(negedge clk_i);
    end
  endtask

  task automatic set_reload(input int rel);
    wr(A_LO, rel[7:0]);
    wr(A_HI, rel[15:8]);
  endtask

  // Stop, clear flag, then start with the given settings.
  task automatic start(input bit ien, input bit per);
    wr(A_CTRL, ctrl_word(1'b0, 1'b0, 1'b1, 1'b0));
    wr(A_CTRL, ctrl_word(1'b1, ien, 1'b0, per));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int per_n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_LO, d);   check("R1 reload lo", d, 0);
    rd(A_HI, d);   check("R1 reload hi", d, 0);
    rd(8'h05, d);  check("R1 unmapped", d, 0);
    check("R1 irq", irq_o, 0);
    check("R1 wdog outputs", {wdog_en_o, wdog_kick_o}, 0);

    // R3 ticks while disabled do nothing
    ticks(5, 0);
    rd(A_CTRL, d); check("R3 idle ticks flag", d[1], 0);

    // R2 staged reload
    wr(A_LO, 8'h34);
    rd(A_LO, d); check("R2 lo staged not visible", d, 8'h00);
    wr(A_HI, 8'h12);
    rd(A_LO, d); check("R2 lo commit", d, 8'h34);
    rd(A_HI, d); check("R2 hi commit", d, 8'h12);

    // R9 busy lockout
    set_reload(6);
    wdog_busy_i = 1'b1;
    wr(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b0, 1'b1));
    rd(A_CTRL, d); check("R9 enable blocked", d[3], 0);
    check("R9 busy readback", d[7], 1);
    wdog_busy_i = 1'b0;

    // R3/R5/R8 periodic directed
    start(1'b1, 1'b1);
    ticks(5, 1);
    rd(A_CTRL, d); check("R3 no early flag", d[1], 0);
    ticks(1, 0);
    rd(A_CTRL, d); check("R3 flag at N", d[1], 1);
    check("R5 enable kept", d[3], 1);
    check("R8 irq", irq_o, exp_irq(1'b1, 1'b1));
    // R7 write 0 leaves flag, write 1 clears
    wr(A_CTRL, ctrl_word(1'b1, 1'b0, 1'b0, 1'b1));
    rd(A_CTRL, d); check("R7 write0 keeps flag", d[1], 1);
    check("R8 irq gated", irq_o, exp_irq(1'b1, 1'b0));
    wr(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b1, 1'b1));
    rd(A_CTRL, d); check("R7 w1c", d[1], 0);
    check("R8 irq low", irq_o, 0);
    ticks(5, 0);
    rd(A_CTRL, d); check("R5 second period early", d[1], 0);
    ticks(1, 0);
    rd(A_CTRL, d); check("R5 second period", d[1], 1);

    // R7 set wins: clear in the same cycle as expiry
    wr(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b1, 1'b1));
    ticks(5, 0);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = A_CTRL;
    wdata_i = ctrl_word(1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd(A_CTRL, d); check("R7 set beats clear", d[1], 1);

    // R6 one-shot
    set_reload(4);
    start(1'b1, 1'b0);
    ticks(4, 2);
    rd(A_CTRL, d); check("R6 flag", d[1], 1);
    check("R6 enable dropped", d[3], 0);
    wr(A_CTRL, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0));
    ticks(10, 0);
    rd(A_CTRL, d); check("R6 no further flag", d[1], 0);

    // R10 restart register
    set_reload(8);
    start(1'b0, 1'b1);
    ticks(5, 0);
    wr(A_RST, 8'h00);
    ticks(7, 0);
    rd(A_CTRL, d); check("R10 restart full period", d[1], 0);
    ticks(1, 0);
    rd(A_CTRL, d); check("R10 expiry after restart", d[1], 1);
    start(1'b0, 1'b1);
    ticks(5, 0);
    wr(A_RST, 8'h05);
    ticks(3, 0);
    rd(A_CTRL, d); check("R10 nonzero ignored", d[1], 1);

    // R3 rate: 0x8000 >> 4 gives 16 Hz, i.e. 2048 ticks
    set_reload(16'h8000 >> 4);
    start(1'b1, 1'b1);
    ticks(2047, 0);
    rd(A_CTRL, d); check("R3 2048 early", d[1], 0);
    ticks(1, 0);
    rd(A_CTRL, d); check("R3 2048 expiry", d[1], 1);

    // R4 reload 0 means 65536
    set_reload(0);
    start(1'b1, 1'b1);
    ticks(65535, 0);
    rd(A_CTRL, d); check("R4 early", d[1], 0);
    ticks(1, 0);
    rd(A_CTRL, d); check("R4 expiry at 65536", d[1], 1);

    // Random periods and modes
    for (int it = 0; it < 12; it++) begin
      int rel;
      bit per;
      bit ien;
      int gap;
      rel = 1 + int'($urandom_range(40));
      per = 1'($urandom_range(1));
      ien = 1'($urandom_range(1));
      gap = int'($urandom_range(3));
      per_n = eff_period(rel);
      set_reload(rel);
      start(ien, per);
      if (per_n > 1) begin
        ticks(per_n - 1, gap);
        rd(A_CTRL, d); check("R3 random early", d[1], 0);
      end
      ticks(1, gap);
      rd(A_CTRL, d); check("R3 random flag", d[1], 1);
      check(per ? "R5 random enable" : "R6 random enable", d[3], per);
      check("R8 random irq", irq_o, exp_irq(1'b1, ien));
    end

    // R11 watchdog bits
    wr(A_CTRL, 8'h40);
    check("R11 enable out", wdog_en_o, 1);
    wr(A_CTRL, 8'h60);
    check("R11 kick pulse", wdog_kick_o, 1);
    rd(A_CTRL, d); check("R11 kick reads 0", d[5], 0);
    @(negedge clk_i);
    check("R11 kick single cycle", wdog_kick_o, 0);
    wdog_bark_i = 1'b1;
    @(negedge clk_i);
    wdog_bark_i = 1'b0;
    rd(A_CTRL, d); check("R11 bark flag", d[4], 1);
    wr(A_CTRL, 8'h40);
    rd(A_CTRL, d); check("R11 flag write0 keeps", d[4], 1);
    wr(A_CTRL, 8'h10);
    rd(A_CTRL, d); check("R11 flag w1c", d[4], 0);
    check("R11 enable cleared", wdog_en_o, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule